// File: doc/BRIEF.md
# Three-wire serial EEPROM command controller

This block is the host side of a three-wire serial EEPROM link (chip select, serial clock, data out to the memory, data back from the memory). A client hands it one command at a time through a valid/ready request port: a 3-bit command code, a 7-bit word address and a 16-bit write word. The controller turns that request into a serial frame of the right length and runs the clock from a parameterised half-period counter. For reads it returns the 16-bit word. For programming commands it reselects the memory and watches the ready/busy level until the memory reports completion or a poll limit runs out.

Each command ends with one response cycle. That cycle carries the read word and an error flag, which is raised only when a poll ran out of time. Between any two selections of the memory, chip select stays low for a programmable number of system clocks. The memory powers up with programming locked, so the client first sends the unlock command before any write or erase.

Top module: `mw_eeprom_host`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select, serial clock and serial data out are low, the request ready is high and the done pulse is low.
- R2: Every frame begins with chip select high and a 1 on serial data out at the first rising serial clock edge. Then come the 2-bit opcode and an 8-bit field (a 0 followed by the 7-bit address for addressed commands), most significant bit first.
- R3: Read, write and write-all frames carry exactly 27 rising serial clock edges. Erase, erase-all, unlock and lock frames carry exactly 11.
- R4: On a read (command 0, opcode 10), the bit returned after the 11th rising edge is dropped. The next 16 bits, sampled as the serial clock falls, form the returned word, most significant bit first.
- R5: Write (command 1, opcode 01, word address) and write-all (command 4, opcode 00, field 01000000) send the 16-bit write word, most significant bit first, after the 11 header bits.
- R6: Erase is command 2 (opcode 11, word address) and erase-all is command 3 (opcode 00, field 10000000). Both send the header only.
- R7: Every high phase and every low phase of the serial clock lasts at least HALF_CYC system clocks. Serial data out only changes while the serial clock is low.
- R8: Once chip select has dropped, it stays low for at least GAP_CYC system clocks before it rises again. This holds between commands and before a ready/busy poll.
- R9: After write, erase, erase-all or write-all, the controller deselects and then reselects the memory exactly once, with no clock edges. It issues the done pulse only after the returned level is high.
- R10: If the returned level stays low for POLL_LIMIT system clocks of polling, the done pulse comes with the error flag high.
- R11: A request is taken only while ready is high. Ready stays low from acceptance until the one-cycle done pulse, and done never coincides with ready.
- R12: Unlock (command 5, field 11000000) and lock (command 6, field 00000000) send 11-bit header frames with no poll. A write sent after lock leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request accepted when valid |
| req_cmd_i | input | 3 | Command code (0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 unlock, 6 lock) |
| req_addr_i | input | 7 | Word address |
| req_wdata_i | input | 16 | Word to write (write, write-all) |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 16 | Word returned by the last read |
| rsp_err_o | output | 1 | Poll ran out of time (valid with done) |
| mw_cs_o | output | 1 | Memory chip select |
| mw_sclk_o | output | 1 | Serial clock |
| mw_di_o | output | 1 | Serial data to the memory |
| mw_do_i | input | 1 | Serial data and ready/busy level from the memory |

## Verification
Some properties hold every cycle and are checked by the bound assertions. These are the serial clock phase widths, the rule that data only moves while the clock is low, that the clock idles low whenever chip select is low, the chip-select low gap, and the handshake rule that ready stays low between acceptance and done. The bench scenarios are the only way to show what the frames carry and what they cause. A memory model decodes every frame, checks the start bit and counts edges. Against it the bench shows read data with the dummy bit removed, writes and erases landing at the right word, a locked write having no effect, one poll per programming command, and the error flag after a stuck-busy memory.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    MW_READ      = 3'd0,
    MW_WRITE     = 3'd1,
    MW_ERASE     = 3'd2,
    MW_ERASE_ALL = 3'd3,
    MW_WRITE_ALL = 3'd4,
    MW_UNLOCK    = 3'd5,
    MW_LOCK      = 3'd6
  } mw_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GAP,
    ST_POLL,
    ST_RESP
  } mw_state_e;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES <= 1) begin : g_one
      logic r_q;
      always_ff @(posedge clk) begin
        if (rst) r_q <= 1'b0;
        else     r_q <= d_i;
      end
      assign q_o = r_q;
    end else begin : g_chain
      logic [STAGES-1:0] r_q;
      always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= {r_q[STAGES-2:0], d_i};
      end
      assign q_o = r_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
  parameter int unsigned HALF_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic tick_o
);

  localparam int unsigned CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || restart_i) cnt_q <= '0;
    else if (!tick_o)     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build
  import mw_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned HDR_W   = 3 + ADDR_W + 1,
  localparam int unsigned FRAME_W = HDR_W + DATA_W,
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [2:0]         cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               prog_o,
  output logic               read_o
);

  localparam logic [ADDR_W-2:0] ZP = '0;

  logic [1:0]        op;
  logic [ADDR_W:0]   fld;
  logic              send_data;
  logic              long_frame;

  always_comb begin
    op         = 2'b00;
    fld        = {1'b0, addr_i};
    send_data  = 1'b0;
    long_frame = 1'b0;
    prog_o     = 1'b0;
    read_o     = 1'b0;
    case (mw_cmd_e'(cmd_i))
      MW_READ: begin
        op = 2'b10; long_frame = 1'b1; read_o = 1'b1;
      end
      MW_WRITE: begin
        op = 2'b01; long_frame = 1'b1; send_data = 1'b1; prog_o = 1'b1;
      end
      MW_ERASE: begin
        op = 2'b11; prog_o = 1'b1;
      end
      MW_ERASE_ALL: begin
        fld = {2'b10, ZP}; prog_o = 1'b1;
      end
      MW_WRITE_ALL: begin
        fld = {2'b01, ZP}; long_frame = 1'b1; send_data = 1'b1; prog_o = 1'b1;
      end
      MW_UNLOCK: fld = {2'b11, ZP};
      default:   fld = {2'b00, ZP};
    endcase
  end

  assign frame_o = {1'b1, op, fld, (send_data ? wdata_i : {DATA_W{1'b0}})};
  assign len_o   = long_frame ? LEN_W'(FRAME_W) : LEN_W'(HDR_W);

endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 50,
  parameter int unsigned GAP_CYC     = 50,
  parameter int unsigned POLL_LIMIT  = 3_400_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              mw_cs_o,
  output logic              mw_sclk_o,
  output logic              mw_di_o,
  input  logic              mw_do_i
);

  localparam int unsigned HDR_W   = 3 + ADDR_W + 1;
  localparam int unsigned FRAME_W = HDR_W + DATA_W;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);
  localparam int unsigned CNT_MAX = (POLL_LIMIT > GAP_CYC) ? POLL_LIMIT : GAP_CYC;
  localparam int unsigned WAIT_W  = $clog2(CNT_MAX + 1);

  mw_state_e          state_q;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [LEN_W-1:0]   len_q, len_d, bit_q;
  logic               prog_q, prog_d, read_q, read_d;
  logic               cs_q, sclk_q, di_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               err_q, done_q;
  logic [WAIT_W-1:0]  wait_q;
  logic               poll_pend_q, armed_q;
  logic               tick, restart, do_s;

  mw_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_build (
    .cmd_i   (req_cmd_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .frame_o (frame_d),
    .len_o   (len_d),
    .prog_o  (prog_d),
    .read_o  (read_d)
  );

  assign restart = tick || (state_q == ST_IDLE) || (state_q == ST_GAP) || (state_q == ST_RESP);

  mw_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .tick_o    (tick)
  );

  mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (mw_do_i),
    .q_o (do_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      frame_q     <= '0;
      len_q       <= '0;
      bit_q       <= '0;
      prog_q      <= 1'b0;
      read_q      <= 1'b0;
      cs_q        <= 1'b0;
      sclk_q      <= 1'b0;
      di_q        <= 1'b0;
      rdata_q     <= '0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
      wait_q      <= '0;
      poll_pend_q <= 1'b0;
      armed_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            frame_q <= frame_d;
            len_q   <= len_d;
            prog_q  <= prog_d;
            read_q  <= read_d;
            bit_q   <= '0;
            cs_q    <= 1'b1;
            sclk_q  <= 1'b0;
            di_q    <= frame_d[FRAME_W-1];
            err_q   <= 1'b0;
            rdata_q <= '0;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk_q  <= 1'b1;
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk_q <= 1'b0;
            if (read_q && (bit_q >= LEN_W'(HDR_W))) begin
              rdata_q <= {rdata_q[DATA_W-2:0], do_s};
            end
            if (bit_q == len_q - LEN_W'(1)) begin
              di_q    <= 1'b0;
              state_q <= ST_TAIL;
            end else begin
              bit_q   <= bit_q + LEN_W'(1);
              frame_q <= frame_q << 1;
              di_q    <= frame_q[FRAME_W-2];
              state_q <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_q        <= 1'b0;
            wait_q      <= '0;
            poll_pend_q <= prog_q;
            state_q     <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (wait_q == WAIT_W'(GAP_CYC - 1)) begin
            wait_q <= '0;
            if (poll_pend_q) begin
              poll_pend_q <= 1'b0;
              armed_q     <= 1'b0;
              cs_q        <= 1'b1;
              state_q     <= ST_POLL;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_RESP;
            end
          end else begin
            wait_q <= wait_q + WAIT_W'(1);
          end
        end
        ST_POLL: begin
          if (tick) armed_q <= 1'b1;
          if (armed_q && do_s) begin
            cs_q    <= 1'b0;
            wait_q  <= '0;
            state_q <= ST_GAP;
          end else if (wait_q == WAIT_W'(POLL_LIMIT - 1)) begin
            err_q   <= 1'b1;
            cs_q    <= 1'b0;
            wait_q  <= '0;
            state_q <= ST_GAP;
          end else begin
            wait_q <= wait_q + WAIT_W'(1);
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_done_o  = done_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;
  assign mw_cs_o     = cs_q;
  assign mw_sclk_o   = sclk_q;
  assign mw_di_o     = di_q;

endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk #(
  parameter int unsigned HALF_CYC = 50,
  parameter int unsigned GAP_CYC  = 50
) (
  input logic clk,
  input logic rst,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic rsp_done_o,
  input logic mw_cs_o,
  input logic mw_sclk_o,
  input logic mw_di_o
);

  localparam int unsigned PW = $clog2(HALF_CYC + 2);
  localparam int unsigned GW = $clog2(GAP_CYC + 2);

  logic          sclk_lvl, cs_lvl;
  logic [PW-1:0] ph_run;
  logic [GW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_lvl <= 1'b0;
      cs_lvl   <= 1'b0;
      ph_run   <= PW'(HALF_CYC);
      low_run  <= GW'(GAP_CYC);
    end else begin
      sclk_lvl <= mw_sclk_o;
      cs_lvl   <= mw_cs_o;
      if (mw_sclk_o != sclk_lvl)      ph_run <= PW'(1);
      else if (ph_run < PW'(HALF_CYC)) ph_run <= ph_run + PW'(1);
      if (mw_cs_o)                    low_run <= '0;
      else if (low_run < GW'(GAP_CYC)) low_run <= low_run + GW'(1);
    end
  end

  // R7
  sclk_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (mw_sclk_o != sclk_lvl) |-> (ph_run >= PW'(HALF_CYC)));

  // R7
  di_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (mw_sclk_o && $past(mw_sclk_o)) |-> $stable(mw_di_o));

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !mw_cs_o |-> !mw_sclk_o);

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (mw_cs_o && !cs_lvl) |-> (low_run >= GW'(GAP_CYC)));

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done_o |-> !req_ready_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done_o |=> !rsp_done_o);

endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(
  .HALF_CYC (HALF_CYC),
  .GAP_CYC  (GAP_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_done_o  (rsp_done_o),
  .mw_cs_o     (mw_cs_o),
  .mw_sclk_o   (mw_sclk_o),
  .mw_di_o     (mw_di_o)
);

// File: tb/mw_eeprom_host_bench.sv
`timescale 1ns/1ps
module mw_eeprom_host_bench;

  localparam int HALF = 4;
  localparam int GAP  = 6;
  localparam int LIM  = 400;
  localparam int BUSY = 150;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_cmd = '0;
  logic [6:0]  in_addr = '0;
  logic [15:0] in_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic        eep_cs, eep_sclk, eep_di, eep_do;

  always #2.5 clk = ~clk;

  mw_eeprom_host #(.HALF_CYC(HALF), .GAP_CYC(GAP), .POLL_LIMIT(LIM)) u_mw_eeprom_host (
    .clk(clk), .rst(rst),
    .req_valid_i(in_valid), .req_ready_o(in_ready),
    .req_cmd_i(in_cmd), .req_addr_i(in_addr), .req_wdata_i(in_wdata),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .mw_cs_o(eep_cs), .mw_sclk_o(eep_sclk), .mw_di_o(eep_di), .mw_do_i(eep_do)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    logic [6:0] a;
    a = 7'(i);
    return {a, ~a, 2'b01};
  endfunction

  // ---------------- memory model ----------------
  logic [15:0] s_mem [128];
  logic        s_wen = 1'b0;
  int          s_cnt = 0;
  logic [26:0] s_sh = '0;
  logic [10:0] s_hdr = '0;
  logic [15:0] s_rd = '0;
  logic        s_rdmode = 1'b0;
  logic        s_do = 1'b0;
  logic        s_tgl = 1'b0;
  logic        s_seen = 1'b0;
  int          s_busy_cnt = 0;
  logic        s_stuck = 1'b0;
  int          s_polls = 0;
  int          len_q[$];

  initial for (int i = 0; i < 128; i++) s_mem[i] = pat(i);

  assign eep_do = !eep_cs ? 1'b0 : ((s_busy_cnt > 0) ? 1'b0 : ((s_cnt == 0) ? 1'b1 : s_do));

  always @(posedge clk) begin
    if (s_tgl != s_seen) begin
      s_seen     <= s_tgl;
      s_busy_cnt <= BUSY;
    end else if (s_busy_cnt > 0 && !s_stuck) begin
      s_busy_cnt <= s_busy_cnt - 1;
    end
  end

  always @(posedge eep_sclk or negedge eep_cs) begin
    if (!eep_cs) begin
      if (s_cnt > 0) begin
        if (len_q.size() == 0) check(1'b0, "R3 unexpected frame", 32'(s_cnt), 0);
        else begin
          int e;
          e = len_q.pop_front();
          check(s_cnt == e, "R3 frame length", 32'(s_cnt), 32'(e));
        end
      end else begin
        s_polls++;
      end
      s_cnt = 0;
      s_rdmode = 1'b0;
      s_do = 1'b0;
    end else begin
      if (s_cnt == 0) check(eep_di == 1'b1, "R2 start bit", 32'(eep_di), 1);
      s_sh = {s_sh[25:0], eep_di};
      s_cnt++;
      if (s_cnt == 11) begin
        s_hdr = s_sh[10:0];
        case (s_hdr[9:8])
          2'b10: begin
            s_rd = s_mem[s_hdr[6:0]];
            s_rdmode = 1'b1;
            s_do = 1'b0;
          end
          2'b11: if (s_wen) begin s_mem[s_hdr[6:0]] = 16'hFFFF; s_tgl = ~s_tgl; end
          default: begin
            if (s_hdr[9:8] == 2'b00) begin
              case (s_hdr[7:6])
                2'b11: s_wen = 1'b1;
                2'b00: s_wen = 1'b0;
                2'b10: if (s_wen) begin
                  for (int i = 0; i < 128; i++) s_mem[i] = 16'hFFFF;
                  s_tgl = ~s_tgl;
                end
                default: ;
              endcase
            end
          end
        endcase
      end else if (s_cnt > 11 && s_cnt <= 27 && s_rdmode) begin
        s_do = s_rd[15];
        s_rd = {s_rd[14:0], 1'b0};
      end
      if (s_cnt == 27 && s_wen) begin
        if (s_hdr[9:8] == 2'b01) begin
          s_mem[s_hdr[6:0]] = s_sh[15:0];
          s_tgl = ~s_tgl;
        end else if (s_hdr[9:8] == 2'b00 && s_hdr[7:6] == 2'b01) begin
          for (int i = 0; i < 128; i++) s_mem[i] = s_sh[15:0];
          s_tgl = ~s_tgl;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [15:0] data;
    bit          chk_data;
    bit          err;
    int          polls_end;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always @(negedge clk) begin
    if (!rst && rsp_done) begin
      if (sb_q.size() == 0) check(1'b0, "R11 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rsp_err == e.err, {e.tag, " R10 error flag"}, 32'(rsp_err), 32'(e.err));
        check(s_polls == e.polls_end, {e.tag, " R9 poll count"}, 32'(s_polls), 32'(e.polls_end));
        if (!e.err) check(s_busy_cnt == 0, {e.tag, " R9 done after ready"}, 32'(s_busy_cnt), 0);
        if (e.chk_data) check(rsp_rdata == e.data, {e.tag, " R4 read word"}, 32'(rsp_rdata), 32'(e.data));
        check(in_ready == 1'b0, "R11 ready low with done", 32'(in_ready), 0);
      end
    end
  end

  // ---------------- waveform widths ----------------
  logic pv_sclk = 1'b0, pv_cs = 1'b0;
  int   run_s = 0, run_c = 0;
  int   min_hi = 1000000, min_lo = 1000000, min_cl = 1000000;
  bit   cs_seen = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (eep_sclk != pv_sclk) begin
        if (pv_sclk) min_hi = (run_s < min_hi) ? run_s : min_hi;
        else         min_lo = (run_s < min_lo) ? run_s : min_lo;
        run_s = 1;
      end else run_s++;
      if (eep_cs && !pv_cs) begin
        if (cs_seen) min_cl = (run_c < min_cl) ? run_c : min_cl;
        cs_seen = 1'b1;
      end
      if (eep_cs) run_c = 0; else run_c++;
      pv_sclk = eep_sclk;
      pv_cs = eep_cs;
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input logic [2:0] cmd, input logic [6:0] addr, input logic [15:0] wd,
                       input logic [15:0] exp_data, input bit chk, input bit err, input string tag);
    exp_t e;
    bit   is_long, is_prog;
    is_long = (cmd == 3'd0 || cmd == 3'd1 || cmd == 3'd4);
    is_prog = (cmd >= 3'd1 && cmd <= 3'd4);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    e.data = exp_data; e.chk_data = chk; e.err = err; e.tag = tag;
    e.polls_end = s_polls + (is_prog ? 1 : 0);
    sb_q.push_back(e);
    len_q.push_back(is_long ? 27 : 11);
    in_cmd = cmd; in_addr = addr; in_wdata = wd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R11 ready low after accept", 32'(in_ready), 0);
    while (sb_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check(eep_cs == 1'b0 && eep_sclk == 1'b0 && eep_di == 1'b0, "R1 pins in reset", {eep_cs, eep_sclk, eep_di}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 1);
    check(rsp_done == 1'b0, "R1 done after reset", 32'(rsp_done), 0);
    check(eep_cs == 1'b0 && eep_sclk == 1'b0, "R1 pins after reset", {eep_cs, eep_sclk}, 0);

    issue(3'd0, 7'd5, 16'h0, pat(5), 1, 0, "R4 initial read");
    issue(3'd1, 7'd5, 16'h1234, 16'h0, 0, 0, "R12 write while locked");
    issue(3'd0, 7'd5, 16'h0, pat(5), 1, 0, "R12 locked word unchanged");
    issue(3'd5, 7'd0, 16'h0, 16'h0, 0, 0, "R12 unlock");
    issue(3'd1, 7'd5, 16'h1234, 16'h0, 0, 0, "R5 write");
    issue(3'd0, 7'd5, 16'h0, 16'h1234, 1, 0, "R5 readback");
    issue(3'd1, 7'd127, 16'h8001, 16'h0, 0, 0, "R5 write top");
    issue(3'd0, 7'd127, 16'h0, 16'h8001, 1, 0, "R5 readback top");
    issue(3'd1, 7'd0, 16'h0000, 16'h0, 0, 0, "R5 write zero");
    issue(3'd0, 7'd0, 16'h0, 16'h0000, 1, 0, "R4 read zero");
    issue(3'd0, 7'd1, 16'h0, pat(1), 1, 0, "R4 neighbour intact");
    issue(3'd2, 7'd5, 16'h0, 16'h0, 0, 0, "R6 erase");
    issue(3'd0, 7'd5, 16'h0, 16'hFFFF, 1, 0, "R6 erased word");
    issue(3'd4, 7'd0, 16'h5A5A, 16'h0, 0, 0, "R5 write all");
    issue(3'd0, 7'd3, 16'h0, 16'h5A5A, 1, 0, "R5 write all word 3");
    issue(3'd0, 7'd126, 16'h0, 16'h5A5A, 1, 0, "R5 write all word 126");
    issue(3'd3, 7'd0, 16'h0, 16'h0, 0, 0, "R6 erase all");
    issue(3'd0, 7'd64, 16'h0, 16'hFFFF, 1, 0, "R6 erase all word 64");
    issue(3'd6, 7'd0, 16'h0, 16'h0, 0, 0, "R12 lock");
    issue(3'd1, 7'd9, 16'h1111, 16'h0, 0, 0, "R12 write after lock");
    issue(3'd0, 7'd9, 16'h0, 16'hFFFF, 1, 0, "R12 locked write ignored");
    issue(3'd5, 7'd0, 16'h0, 16'h0, 0, 0, "R12 unlock again");
    s_stuck = 1'b1;
    issue(3'd1, 7'd20, 16'hBEEF, 16'h0, 0, 1, "R10 stuck busy");
    s_stuck = 1'b0;
    repeat (BUSY + 50) @(negedge clk);
    issue(3'd0, 7'd20, 16'h0, 16'hBEEF, 1, 0, "R4 read after timeout");

    check(min_hi >= HALF, "R7 clock high width", 32'(min_hi), HALF);
    check(min_lo >= HALF, "R7 clock low width", 32'(min_lo), HALF);
    check(min_cl >= GAP, "R8 select low gap", 32'(min_cl), GAP);
    check(len_q.size() == 0, "R3 all frames seen", 32'(len_q.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule